// File: doc/BRIEF.md
# 16-bit Capture/Reload Timer

This peripheral holds a 16-bit counter and a 16-bit register pair. The pair is either the capture destination or the reload source, depending on the mode. Software reaches the block through a byte-wide special-function-register port. It drives an address, write data and a write strobe, and it gets back registered read data. The counter advances by one step on every clock where the run bit is set and the `cnt_tick` input is high.

In capture mode, the block watches a falling edge on the external pin, taken through a synchroniser. On that edge it copies the running count into the register pair. An option can clear the counter at that same moment. In reload mode, the counter refills itself from the register pair and raises an overflow flag. A direction option lets the external pin choose between counting up and counting down. The two sticky flags are ORed into one registered interrupt request.

Top module: `cr_timer16`

## Requirements
- R1: After a synchronous reset, every register is 0: the counter, the register pair, the control and mode registers, both flags, `irq` and `sfr_rdata`.
- R2: Register map:
  - C8h is control.
  - C9h is mode.
  - CAh and CBh are the low and high bytes of the pair.
  - CCh and CDh are the low and high bytes of the counter.

  `sfr_rdata` shows the register at the address presented one clock earlier. Any other address reads 00h.
- R3: Control register bits: bit 7 is the overflow flag, bit 6 is the external flag, bit 3 is the external enable, bit 2 is run and bit 0 is capture mode (1) or reload mode (0). Mode register bits: bit 3 is capture-reset and bit 0 is down-count enable. Every other bit of these two registers ignores writes and reads as 0.
- R4: The counter changes only on a clock where run=1 and `cnt_tick`=1, or through a pin event or a software write. With run=0 or `cnt_tick`=0 it holds its value.
- R5: In capture mode with the external enable set, a falling edge on `ext_pin` acts on the third rising clock edge after the pin changes. At that edge it copies the count into the pair, using the value before any advance in that same cycle, and it sets the external flag. With the external enable at 0, the edge has no effect.
- R6: In capture mode with capture-reset set, the capture edge loads the counter with 0000h, and this takes priority over any advance in that cycle.
- R7: In capture mode the counter always counts up. It wraps from FFFFh to 0000h, sets the overflow flag, and leaves the pair unchanged.
- R8: In reload mode with down-count enable at 0, an advance from FFFFh loads the pair value into the counter and sets the overflow flag.
- R9: In reload mode with down-count enable at 1:
  - A high synchronised pin counts up, with the same reload on FFFFh as R8.
  - A low pin counts down. An advance while the count equals the pair value loads FFFFh and sets the overflow flag.
- R10: In reload mode with down-count enable at 0 and the external enable at 1, a synchronised falling edge loads the pair value into the counter and sets the external flag. This takes priority over an advance in the same cycle.
- R11: Both flags stay set until software writes them. A software write can set or clear a flag, but a hardware set in the same cycle wins. `irq` is the OR of the two flags and is updated on the same edge as the flags.
- R12: A software write to one byte of the counter or of the pair takes priority over any hardware update of that byte in the same cycle. The other byte still takes its hardware value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe |
| sfr_rdata | output | 8 | Registered read data of the previous cycle's address |
| cnt_tick | input | 1 | Count pulse; the counter advances when run is set |
| ext_pin | input | 1 | External capture/reload/direction pin, asynchronous |
| irq | output | 1 | Registered OR of the overflow and external flags |

## Verification
Every internal state of this block can be read back through the register port one clock after the address is presented. A wrong counter, register pair or flag therefore shows up in `sfr_rdata` on the next read of that address. A wrong flag also shows up on `irq` on the same edge where the flag goes wrong. A fault in the synchroniser shifts a capture or reload by whole cycles. With the counter running, a one-cycle shift changes the captured value by one step, so a single read of the pair exposes it. A fault in the direction choice or in the reload compare shows up as a wrong count value and a missing or extra overflow flag on the very advance where the boundary is crossed.

// File: rtl/cr_timer16_pkg.sv
package cr_timer16_pkg;
  localparam logic [7:0] ADR_CTRL = 8'hC8;
  localparam logic [7:0] ADR_MODE = 8'hC9;
  localparam logic [7:0] ADR_PRL  = 8'hCA;
  localparam logic [7:0] ADR_PRH  = 8'hCB;
  localparam logic [7:0] ADR_CNL  = 8'hCC;
  localparam logic [7:0] ADR_CNH  = 8'hCD;

  localparam int B_OVF   = 7;
  localparam int B_EXT   = 6;
  localparam int B_EXEN  = 3;
  localparam int B_RUN   = 2;
  localparam int B_CAPM  = 0;
  localparam int B_CRST  = 3;
  localparam int B_DOWN  = 0;

  typedef struct packed {
    logic exen;
    logic run;
    logic capm;
    logic crst;
    logic down_en;
  } tmr_cfg_t;
endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], pin_async};
      prev <= sr[STAGES-1];
    end
  end

  assign level = sr[STAGES-1];
  assign fall  = prev & ~sr[STAGES-1];
endmodule

// File: rtl/cr_count_unit.sv
module cr_count_unit
  import cr_timer16_pkg::*;
#(
  parameter int B_W = 8,
  parameter int NB  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  tmr_cfg_t        cfg,
  input  logic            adv,
  input  logic            fall,
  input  logic            level,
  input  logic [NB-1:0]   wr_cnt,
  input  logic [NB-1:0]   wr_par,
  input  logic [B_W-1:0]  wdata,
  output logic [NB*B_W-1:0] cnt,
  output logic [NB*B_W-1:0] par,
  output logic            ovf_set,
  output logic            ext_set
);
  localparam int W = NB * B_W;
  localparam logic [W-1:0] MAXV = '1;

  logic         cap_ev, rld_ev, up;
  logic [W-1:0] cnt_hw, par_hw, cnt_nx, par_nx;

  assign cap_ev  = cfg.capm & cfg.exen & fall;
  assign rld_ev  = ~cfg.capm & ~cfg.down_en & cfg.exen & fall;
  assign up      = ~cfg.down_en | level;
  assign ext_set = cap_ev | rld_ev;
  assign par_hw  = cap_ev ? cnt : par;

  always_comb begin
    cnt_hw  = cnt;
    ovf_set = 1'b0;
    if (cfg.capm) begin
      if (cap_ev && cfg.crst) begin
        cnt_hw = '0;
      end else if (adv) begin
        cnt_hw  = cnt + 1'b1;
        ovf_set = (cnt == MAXV);
      end
    end else if (rld_ev) begin
      cnt_hw = par;
    end else if (adv) begin
      if (up) begin
        if (cnt == MAXV) begin
          cnt_hw  = par;
          ovf_set = 1'b1;
        end else begin
          cnt_hw = cnt + 1'b1;
        end
      end else if (cnt == par) begin
        cnt_hw  = MAXV;
        ovf_set = 1'b1;
      end else begin
        cnt_hw = cnt - 1'b1;
      end
    end
  end

  always_comb begin
    cnt_nx = cnt_hw;
    par_nx = par_hw;
    for (int b = 0; b < NB; b++) begin
      if (wr_cnt[b]) cnt_nx[b*B_W +: B_W] = wdata;
      if (wr_par[b]) par_nx[b*B_W +: B_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      par <= '0;
    end else begin
      cnt <= cnt_nx;
      par <= par_nx;
    end
  end

  // R5: capture copies the pre-advance count
  a_r5_capture_value: assert property (@(posedge clk) disable iff (rst)
    (cap_ev && wr_par == '0) |=> (par == $past(cnt)));
  // R6: capture-reset clears the counter
  a_r6_capture_clears: assert property (@(posedge clk) disable iff (rst)
    (cap_ev && cfg.crst && wr_cnt == '0) |=> (cnt == '0));
  // R8: up overflow reloads from the pair
  a_r8_up_reload: assert property (@(posedge clk) disable iff (rst)
    (!cfg.capm && !rld_ev && adv && up && cnt == MAXV && wr_cnt == '0)
      |=> (cnt == $past(par)));
  // R9: down count at the pair value wraps to all ones
  a_r9_down_wrap: assert property (@(posedge clk) disable iff (rst)
    (!cfg.capm && !rld_ev && adv && !up && cnt == par && wr_cnt == '0)
      |=> (cnt == MAXV));
  // R4: no advance, no event, no write keeps the count
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !cap_ev && !rld_ev && wr_cnt == '0) |=> $stable(cnt));
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import cr_timer16_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              cnt_tick,
  input  logic              ext_pin,
  output logic              irq
);
  localparam int NB    = 2;
  localparam int CNT_W = NB * DATA_W;

  tmr_cfg_t          cfg;
  logic              ovf_q, ext_q, irq_q;
  logic              ovf_nx, ext_nx;
  logic              pin_lvl, pin_fall;
  logic              ovf_set, ext_set;
  logic [CNT_W-1:0]  cnt, par;
  logic [NB-1:0]     wr_cnt, wr_par;
  logic              wr_ctrl, wr_mode;
  logic [DATA_W-1:0] rd_mux, rd_q;

  assign wr_ctrl   = sfr_we && (sfr_addr == ADDR_W'(ADR_CTRL));
  assign wr_mode   = sfr_we && (sfr_addr == ADDR_W'(ADR_MODE));
  assign wr_par[0] = sfr_we && (sfr_addr == ADDR_W'(ADR_PRL));
  assign wr_par[1] = sfr_we && (sfr_addr == ADDR_W'(ADR_PRH));
  assign wr_cnt[0] = sfr_we && (sfr_addr == ADDR_W'(ADR_CNL));
  assign wr_cnt[1] = sfr_we && (sfr_addr == ADDR_W'(ADR_CNH));

  cr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (ext_pin),
    .level     (pin_lvl),
    .fall      (pin_fall)
  );

  cr_count_unit #(.B_W(DATA_W), .NB(NB)) u_count (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .adv     (cfg.run & cnt_tick),
    .fall    (pin_fall),
    .level   (pin_lvl),
    .wr_cnt  (wr_cnt),
    .wr_par  (wr_par),
    .wdata   (sfr_wdata),
    .cnt     (cnt),
    .par     (par),
    .ovf_set (ovf_set),
    .ext_set (ext_set)
  );

  always_comb begin
    ovf_nx = (wr_ctrl ? sfr_wdata[B_OVF] : ovf_q) | ovf_set;
    ext_nx = (wr_ctrl ? sfr_wdata[B_EXT] : ext_q) | ext_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= ovf_nx;
      ext_q <= ext_nx;
      irq_q <= ovf_nx | ext_nx;
      if (wr_ctrl) begin
        cfg.exen <= sfr_wdata[B_EXEN];
        cfg.run  <= sfr_wdata[B_RUN];
        cfg.capm <= sfr_wdata[B_CAPM];
      end
      if (wr_mode) begin
        cfg.crst    <= sfr_wdata[B_CRST];
        cfg.down_en <= sfr_wdata[B_DOWN];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sfr_addr)
      ADDR_W'(ADR_CTRL): begin
        rd_mux[B_OVF]  = ovf_q;
        rd_mux[B_EXT]  = ext_q;
        rd_mux[B_EXEN] = cfg.exen;
        rd_mux[B_RUN]  = cfg.run;
        rd_mux[B_CAPM] = cfg.capm;
      end
      ADDR_W'(ADR_MODE): begin
        rd_mux[B_CRST] = cfg.crst;
        rd_mux[B_DOWN] = cfg.down_en;
      end
      ADDR_W'(ADR_PRL): rd_mux = par[DATA_W-1:0];
      ADDR_W'(ADR_PRH): rd_mux = par[CNT_W-1:DATA_W];
      ADDR_W'(ADR_CNL): rd_mux = cnt[DATA_W-1:0];
      ADDR_W'(ADR_CNH): rd_mux = cnt[CNT_W-1:DATA_W];
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign sfr_rdata = rd_q;
  assign irq       = irq_q;

  // R11: a hardware overflow event always leaves the flag set
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_set |=> ovf_q);
  // R11: a hardware pin event always leaves the external flag set
  a_r11_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    ext_set |=> ext_q);
  // R3: reserved mode bits read as zero
  a_r3_mode_reserved: assert property (@(posedge clk) disable iff (rst)
    (sfr_addr == ADDR_W'(ADR_MODE)) |=> (sfr_rdata[7:4] == 4'h0 && sfr_rdata[2:1] == 2'b00));
endmodule

// File: tb/test_cr_timer16.sv
module test_cr_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] wd = 8'h00;
  logic       we = 1'b0;
  logic       tick = 1'b0;
  logic       pin = 1'b1;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cr_timer16 i_cr_timer16 (
    .clk(clk), .rst(rst), .sfr_addr(addr), .sfr_wdata(wd), .sfr_we(we),
    .sfr_rdata(rdata), .cnt_tick(tick), .ext_pin(pin), .irq(irq)
  );

  // ---------------- reference model, built from the requirements ----------
  logic [15:0] m_cnt, m_par;
  logic m_ovf, m_ext, m_exen, m_run, m_capm, m_crst, m_down, m_irq;
  logic m_s0, m_s1, m_prev;
  logic [7:0] m_rd;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'hC8: return {m_ovf, m_ext, 2'b00, m_exen, m_run, 1'b0, m_capm};
      8'hC9: return {4'h0, m_crst, 2'b00, m_down};
      8'hCA: return m_par[7:0];
      8'hCB: return m_par[15:8];
      8'hCC: return m_cnt[7:0];
      8'hCD: return m_cnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic fall, up, cev, rev, os, no, ne;
    logic [15:0] nc, np;
    if (rst) begin
      m_cnt = '0; m_par = '0; m_ovf = 0; m_ext = 0; m_exen = 0; m_run = 0;
      m_capm = 0; m_crst = 0; m_down = 0; m_irq = 0; m_s0 = 0; m_s1 = 0;
      m_prev = 0; m_rd = '0;
    end else begin
      m_rd = m_read(addr);
      fall = m_prev & ~m_s1;
      cev  = m_capm & m_exen & fall;
      rev  = ~m_capm & ~m_down & m_exen & fall;
      up   = ~m_down | m_s1;
      os   = 1'b0;
      nc   = m_cnt;
      np   = cev ? m_cnt : m_par;
      if (m_capm) begin
        if (cev && m_crst) nc = 16'h0000;
        else if (m_run && tick) begin
          os = (m_cnt == 16'hFFFF);
          nc = m_cnt + 16'd1;
        end
      end else if (rev) begin
        nc = m_par;
      end else if (m_run && tick) begin
        if (up) begin
          if (m_cnt == 16'hFFFF) begin nc = m_par; os = 1'b1; end
          else nc = m_cnt + 16'd1;
        end else begin
          if (m_cnt == m_par) begin nc = 16'hFFFF; os = 1'b1; end
          else nc = m_cnt - 16'd1;
        end
      end
      no = m_ovf;
      ne = m_ext;
      if (we) begin
        case (addr)
          8'hC8: begin no = wd[7]; ne = wd[6]; m_exen = wd[3]; m_run = wd[2]; m_capm = wd[0]; end
          8'hC9: begin m_crst = wd[3]; m_down = wd[0]; end
          8'hCA: np[7:0]  = wd;
          8'hCB: np[15:8] = wd;
          8'hCC: nc[7:0]  = wd;
          8'hCD: nc[15:8] = wd;
          default: ;
        endcase
      end
      m_ovf = no | os;
      m_ext = ne | cev | rev;
      m_cnt = nc;
      m_par = np;
      m_irq = m_ovf | m_ext;
      m_prev = m_s1;
      m_s1 = m_s0;
      m_s0 = pin;
    end
  end

  // ---------------- helpers ----------------
  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic sfr_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(posedge clk);
    #1;
    check8(rdata, exp, req);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'hC8: return "R11";
      8'hC9: return "R3";
      8'hCA, 8'hCB: return "R5";
      8'hCC, 8'hCD: return "R4";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2: reset values and map
    sfr_rd(8'hC8, 8'h00, "R1");
    sfr_rd(8'hC9, 8'h00, "R1");
    sfr_rd(8'hCA, 8'h00, "R1");
    sfr_rd(8'hCB, 8'h00, "R1");
    sfr_rd(8'hCC, 8'h00, "R1");
    sfr_rd(8'hCD, 8'h00, "R1");
    check8({7'd0, irq}, 8'h00, "R1 irq");
    sfr_rd(8'hCE, 8'h00, "R2 unmapped");

    // R12 / R2: pair bytes written and read back
    sfr_wr(8'hCA, 8'h34);
    sfr_wr(8'hCB, 8'h12);
    sfr_rd(8'hCA, 8'h34, "R12");
    sfr_rd(8'hCB, 8'h12, "R12");
    // R3: reserved bits
    sfr_wr(8'hC9, 8'hFF);
    sfr_rd(8'hC9, 8'h09, "R3 mode");
    sfr_wr(8'hC8, 8'hFF);
    sfr_rd(8'hC8, 8'hCD, "R3 ctrl");
    check8({7'd0, irq}, 8'h01, "R11 irq set by write");
    sfr_wr(8'hC8, 8'h00);
    sfr_wr(8'hC9, 8'h00);
    sfr_rd(8'hC8, 8'h00, "R11 clear");

    // R5: capture
    sfr_wr(8'hCC, 8'h34);
    sfr_wr(8'hCD, 8'h12);
    sfr_wr(8'hCA, 8'h00);
    sfr_wr(8'hCB, 8'h00);
    sfr_wr(8'hC8, 8'h09);
    @(negedge clk); pin = 1'b0;
    idle(5);
    sfr_rd(8'hCA, 8'h34, "R5");
    sfr_rd(8'hCB, 8'h12, "R5");
    sfr_rd(8'hC8, 8'h49, "R5 flag");
    check8({7'd0, irq}, 8'h01, "R11 irq");

    // R5: external enable off ignores the edge
    sfr_wr(8'hC8, 8'h01);
    sfr_wr(8'hCC, 8'h99);
    @(negedge clk); pin = 1'b1; idle(4);
    @(negedge clk); pin = 1'b0; idle(5);
    sfr_rd(8'hCA, 8'h34, "R5 exen off");
    sfr_rd(8'hC8, 8'h01, "R5 exen off flag");

    // R6: capture-reset
    sfr_wr(8'hC8, 8'h09);
    sfr_wr(8'hC9, 8'h08);
    sfr_wr(8'hCC, 8'h78);
    sfr_wr(8'hCD, 8'h56);
    @(negedge clk); pin = 1'b1; idle(4);
    @(negedge clk); pin = 1'b0; idle(5);
    sfr_rd(8'hCC, 8'h00, "R6");
    sfr_rd(8'hCD, 8'h00, "R6");
    sfr_rd(8'hCB, 8'h56, "R6 captured");

    // R7: capture-mode wrap
    sfr_wr(8'hC8, 8'h05);
    sfr_wr(8'hC9, 8'h00);
    sfr_wr(8'hCC, 8'hFE);
    sfr_wr(8'hCD, 8'hFF);
    ticks(3);
    sfr_rd(8'hCC, 8'h01, "R7");
    sfr_rd(8'hCD, 8'h00, "R7");
    sfr_rd(8'hC8, 8'h85, "R7 flag");
    sfr_rd(8'hCB, 8'h56, "R7 pair kept");

    // R8: up reload
    sfr_wr(8'hC8, 8'h04);
    sfr_wr(8'hCA, 8'h00);
    sfr_wr(8'hCB, 8'hF0);
    sfr_wr(8'hCC, 8'hFF);
    sfr_wr(8'hCD, 8'hFF);
    ticks(1);
    sfr_rd(8'hCD, 8'hF0, "R8");
    sfr_rd(8'hCC, 8'h00, "R8");
    sfr_rd(8'hC8, 8'h84, "R8 flag");

    // R9: down count with pin low, then up with pin high
    sfr_wr(8'hC8, 8'h04);
    sfr_wr(8'hC9, 8'h01);
    sfr_wr(8'hCC, 8'h01);
    sfr_wr(8'hCD, 8'hF0);
    ticks(1);
    sfr_rd(8'hCC, 8'h00, "R9 down");
    sfr_rd(8'hC8, 8'h04, "R9 no flag yet");
    ticks(1);
    sfr_rd(8'hCC, 8'hFF, "R9 wrap");
    sfr_rd(8'hCD, 8'hFF, "R9 wrap");
    sfr_rd(8'hC8, 8'h84, "R9 flag");
    @(negedge clk); pin = 1'b1; idle(4);
    ticks(1);
    sfr_rd(8'hCD, 8'hF0, "R9 up reload");
    sfr_rd(8'hCC, 8'h00, "R9 up reload");

    // R10: pin-triggered reload
    sfr_wr(8'hC8, 8'h08);
    sfr_wr(8'hC9, 8'h00);
    sfr_wr(8'hCA, 8'hCD);
    sfr_wr(8'hCB, 8'hAB);
    sfr_wr(8'hCC, 8'h01);
    sfr_wr(8'hCD, 8'h00);
    @(negedge clk); pin = 1'b0; idle(5);
    sfr_rd(8'hCD, 8'hAB, "R10");
    sfr_rd(8'hCC, 8'hCD, "R10");
    sfr_rd(8'hC8, 8'h48, "R10 flag");
    check8({7'd0, irq}, 8'h01, "R10 irq");

    // R4: hold without tick, hold without run
    sfr_wr(8'hC8, 8'h04);
    sfr_wr(8'hCC, 8'h10);
    sfr_wr(8'hCD, 8'h00);
    idle(5);
    sfr_rd(8'hCC, 8'h10, "R4 no tick");
    sfr_wr(8'hC8, 8'h00);
    ticks(4);
    sfr_rd(8'hCC, 8'h10, "R4 no run");
    sfr_wr(8'hC8, 8'h04);
    ticks(4);
    sfr_rd(8'hCC, 8'h14, "R4 run");
    check8({7'd0, irq}, 8'h00, "R11 irq clear");

    // random phase against the model (covers R11, R12 same-cycle races)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 5) == 0) pin = ~pin;
      case ($urandom_range(0, 7))
        0: ra = 8'hC8;
        1: ra = 8'hC9;
        2: ra = 8'hCA;
        3: ra = 8'hCB;
        4: ra = 8'hCC;
        5: ra = 8'hCD;
        6: ra = 8'hC8;
        default: ra = 8'($urandom);
      endcase
      addr = ra;
      we = ($urandom_range(0, 9) == 0);
      wd = 8'($urandom);
      if (we && ra == 8'hC8 && $urandom_range(0, 1) == 0) wd[2] = 1'b1;
      if (we && (ra == 8'hCC || ra == 8'hCD) && $urandom_range(0, 3) == 0) wd = 8'hFF;
      @(posedge clk);
      #1;
      check8(rdata, m_rd, we ? "R12" : tag_of(ra));
      check8({7'd0, irq}, {7'd0, m_irq}, "R11 irq");
    end
    @(negedge clk);
    we = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule